// File: doc/BRIEF.md
# Toggle-Handshake Word Crossing Between Unrelated Clocks

This block carries a multi-bit word, typically a free-running count, from a producer running on one clock to a consumer running on a second clock. The two clocks have no fixed phase or frequency relationship. The word itself never passes through synchronizer flops, because its bits could settle one clock apart and form a word that never existed. Only two single-bit control levels cross between the domains. One is a request that travels from source to destination. The other is an acknowledge that travels back. Each passes through a chain of flops whose depth is a parameter.

A transfer is announced by inverting a level; a pulse is not used. When the source is idle it copies the producer word into a holding register and flips the request at the same edge. It then leaves the holding register alone until the acknowledge it sees matches the request again. The destination detects the change in the synchronized request. It copies the holding register into its output register, raises a one-cycle valid strobe and flips the acknowledge. Each domain has its own asynchronous active-high reset. Both resets are expected to be applied together. The source begins a new transfer on its own as soon as the previous one is acknowledged, so the consumer sees a steady stream of recent samples.

Top module: `toggle_bus_cdc`

## Requirements
- R1: While src_rst is high, src_take is 0. While dst_rst is high, dst_valid is 0 and dst_word is 0. After both resets are applied mid-run and released, transfers start again from an empty state.
- R2: src_take is high for one source cycle each time the holding register is loaded. Two consecutive rises of src_take are at least SYNC_STAGES+1 source cycles apart.
- R3: The dst_word presented with each dst_valid equals the src_word present at the source edge that raised the matching src_take, taken in the same order. When the producer word never decreases, the delivered words never decrease.
- R4: dst_valid is high for exactly one destination cycle per transfer. Each src_take produces exactly one dst_valid, so no word is lost or repeated. At any moment at most one transfer is in flight.
- R5: dst_word changes only in the cycle in which dst_valid is high, and holds its value otherwise.
- R6: The holding register in the source does not change while a transfer is unacknowledged, that is while the request level differs from the synchronized acknowledge.
- R7: dst_valid rises no later than SYNC_STAGES+2 destination clock periods after the source edge that raised src_take. This holds whether the destination clock is slower or faster than the source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain asynchronous reset, active high |
| src_word | input | DATA_W | Producer value, sampled when a transfer starts |
| src_take | output | 1 | One-cycle strobe: src_word was sampled at the previous source edge |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain asynchronous reset, active high |
| dst_word | output | DATA_W | Last word delivered to the destination domain |
| dst_valid | output | 1 | One-cycle strobe: dst_word was just updated |

## Verification
In the source domain, the arrival of the returning acknowledge and the sampling of the next producer word fall on the same edge as a change in the producer word. The bench changes src_word after almost every source edge with random steps. It judges each delivered word against the value present just before the sampling edge, not the one written after it. In the destination domain, a new request can be detected in the cycle right after the previous valid strobe ends. The bench runs the destination both slower (17 ns) and faster (6.5 ns) than the source. It checks that strobes never merge and that dst_word holds still between them.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

   // legal depth range of a single-bit synchronizer chain
   localparam int unsigned SYNC_MIN = 2;
   localparam int unsigned SYNC_MAX = 3;

   // width of a saturating spacing counter able to hold SYNC_MAX+1 and more
   localparam int unsigned GAP_W = $clog2(SYNC_MAX + 3) + 1;

   function automatic bit sync_depth_ok(input int unsigned depth);
      return (depth >= SYNC_MIN) && (depth <= SYNC_MAX);
   endfunction

   function automatic bit data_width_ok(input int unsigned width);
      return width >= 1;
   endfunction

endpackage

// File: rtl/tbc_level_sync.sv
module tbc_level_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         stage_q <= '0;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d};
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tbc_source.sv
module tbc_source #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst,
   input  logic [DATA_W-1:0] src_word,
   input  logic              ack_lvl,
   output logic              req_lvl,
   output logic              ack_seen,
   output logic [DATA_W-1:0] hold_q,
   output logic              take_q
);

   logic idle;

   tbc_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk (src_clk),
      .rst (src_rst),
      .d   (ack_lvl),
      .q   (ack_seen)
   );

   // equal levels: the last offer has been answered
   assign idle = (ack_seen == req_lvl);

   always_ff @(posedge src_clk or posedge src_rst) begin
      if (src_rst) begin
         req_lvl <= 1'b0;
         hold_q  <= '0;
         take_q  <= 1'b0;
      end else begin
         take_q <= idle;
         if (idle) begin
            req_lvl <= ~req_lvl;
            hold_q  <= src_word;
         end
      end
   end

endmodule

// File: rtl/tbc_dest.sv
module tbc_dest #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              dst_clk,
   input  logic              dst_rst,
   input  logic              req_lvl,
   input  logic [DATA_W-1:0] hold_q,
   output logic              ack_lvl,
   output logic [DATA_W-1:0] dst_word,
   output logic              dst_valid
);

   logic req_seen;
   logic req_last;
   logic fresh;

   tbc_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk (dst_clk),
      .rst (dst_rst),
      .d   (req_lvl),
      .q   (req_seen)
   );

   // a level change on the synchronized request marks a new offer
   assign fresh = req_seen ^ req_last;

   always_ff @(posedge dst_clk or posedge dst_rst) begin
      if (dst_rst) begin
         req_last  <= 1'b0;
         ack_lvl   <= 1'b0;
         dst_word  <= '0;
         dst_valid <= 1'b0;
      end else begin
         req_last  <= req_seen;
         dst_valid <= fresh;
         if (fresh) begin
            dst_word <= hold_q;
            ack_lvl  <= ~ack_lvl;
         end
      end
   end

endmodule

// File: rtl/toggle_bus_cdc.sv
module toggle_bus_cdc
   import tbc_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst,
   input  logic [DATA_W-1:0] src_word,
   output logic              src_take,
   input  logic              dst_clk,
   input  logic              dst_rst,
   output logic [DATA_W-1:0] dst_word,
   output logic              dst_valid
);

   if (!sync_depth_ok(SYNC_STAGES)) begin : g_bad_depth
      $error("toggle_bus_cdc: SYNC_STAGES must lie in 2..3");
   end
   if (!data_width_ok(DATA_W)) begin : g_bad_width
      $error("toggle_bus_cdc: DATA_W must be at least 1");
   end

   logic              req_lvl;
   logic              ack_lvl;
   logic              ack_seen;
   logic [DATA_W-1:0] hold_q;

   tbc_source #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_source (
      .src_clk  (src_clk),
      .src_rst  (src_rst),
      .src_word (src_word),
      .ack_lvl  (ack_lvl),
      .req_lvl  (req_lvl),
      .ack_seen (ack_seen),
      .hold_q   (hold_q),
      .take_q   (src_take)
   );

   tbc_dest #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dest (
      .dst_clk   (dst_clk),
      .dst_rst   (dst_rst),
      .req_lvl   (req_lvl),
      .hold_q    (hold_q),
      .ack_lvl   (ack_lvl),
      .dst_word  (dst_word),
      .dst_valid (dst_valid)
   );

endmodule

// File: rtl/tbc_checker.sv
module tbc_checker
   import tbc_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              src_clk,
   input logic              src_rst,
   input logic              src_take,
   input logic              req_lvl,
   input logic              ack_seen,
   input logic [DATA_W-1:0] hold_q,
   input logic              dst_clk,
   input logic              dst_rst,
   input logic              ack_lvl,
   input logic              dst_valid,
   input logic [DATA_W-1:0] dst_word
);

   localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(SYNC_STAGES + 1);

   // source cycles since the last take strobe, saturating
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge src_clk or posedge src_rst) begin
      if (src_rst) begin
         gap_q <= '1;
      end else if (src_take) begin
         gap_q <= GAP_W'(1);
      end else if (gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R2: take strobe lasts one cycle
   assert_take_pulse_R2: assert property (@(posedge src_clk) disable iff (src_rst)
      src_take |=> !src_take);

   // R2: minimum spacing between loads of the holding register
   assert_take_gap_R2: assert property (@(posedge src_clk) disable iff (src_rst)
      src_take |-> (gap_q >= GAP_MIN));

   // R6: holding register frozen while the offer is unanswered
   assert_hold_frozen_R6: assert property (@(posedge src_clk) disable iff (src_rst)
      (req_lvl != ack_seen) |=> $stable(hold_q));

   // R4: valid strobe lasts one cycle
   assert_valid_pulse_R4: assert property (@(posedge dst_clk) disable iff (dst_rst)
      dst_valid |=> !dst_valid);

   // R4: every delivery answers with an acknowledge flip
   assert_ack_flip_R4: assert property (@(posedge dst_clk) disable iff (dst_rst)
      dst_valid |-> (ack_lvl != $past(ack_lvl)));

   // R5: output word steady between deliveries
   assert_word_hold_R5: assert property (@(posedge dst_clk) disable iff (dst_rst)
      !dst_valid |-> $stable(dst_word));

endmodule

bind toggle_bus_cdc tbc_checker #(
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_tbc_checker (
   .src_clk   (src_clk),
   .src_rst   (src_rst),
   .src_take  (src_take),
   .req_lvl   (req_lvl),
   .ack_seen  (ack_seen),
   .hold_q    (hold_q),
   .dst_clk   (dst_clk),
   .dst_rst   (dst_rst),
   .ack_lvl   (ack_lvl),
   .dst_valid (dst_valid),
   .dst_word  (dst_word)
);

// File: tb/toggle_bus_cdc_bench.sv
`timescale 1ns/1ps
module toggle_bus_cdc_bench;

   localparam int DW = 16;
   localparam int SS = 2;

   logic          src_clk = 1'b0;
   logic          dst_clk = 1'b0;
   logic          src_rst = 1'b0;
   logic          dst_rst = 1'b0;
   logic [DW-1:0] src_word = '0;
   logic          src_take;
   logic [DW-1:0] dst_word;
   logic          dst_valid;

   real dst_half = 8.5;

   always #5 src_clk = ~src_clk;
   always #(dst_half) dst_clk = ~dst_clk;

   toggle_bus_cdc #(.DATA_W(DW), .SYNC_STAGES(SS)) u_toggle_bus_cdc (
      .src_clk   (src_clk),
      .src_rst   (src_rst),
      .src_word  (src_word),
      .src_take  (src_take),
      .dst_clk   (dst_clk),
      .dst_rst   (dst_rst),
      .dst_word  (dst_word),
      .dst_valid (dst_valid)
   );

   int            checks = 0;
   int            fails  = 0;
   bit            done   = 0;
   bit            mon_on = 0;
   logic [DW-1:0] exp_q[$];
   realtime       t_q[$];
   logic [DW-1:0] src_prev = '0;
   int            takes  = 0;
   int            valids = 0;
   int            gap    = 100;
   logic [DW-1:0] last_out = '0;
   bit            last_valid = 0;
   logic [DW-1:0] last_pop = '0;
   bit            have_pop = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
   endtask

   function automatic longint lat_limit();
      return longint'((SS + 2) * 2.0 * dst_half);
   endfunction

   // source side: record what each take strobe latched (R2, R3)
   always @(negedge src_clk) begin
      if (mon_on && !src_rst) begin
         if (src_take) begin
            check(gap >= SS + 1, "R2", "take spacing", gap, SS + 1);
            exp_q.push_back(src_prev);
            t_q.push_back($realtime);
            takes++;
            gap = 1;
         end else begin
            gap++;
         end
      end
   end

   // destination side: match deliveries against recorded samples
   always @(negedge dst_clk) begin : dst_mon
      logic [DW-1:0] e;
      realtime       t;
      if (mon_on && !dst_rst) begin
         if (dst_valid) begin
            valids++;
            check(!last_valid, "R4", "valid width", 2, 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "valid without take", 1, 0);
            end else begin
               e = exp_q.pop_front();
               t = t_q.pop_front();
               check(dst_word == e, "R3", "delivered word", dst_word, e);
               if (have_pop)
                  check(dst_word >= last_pop, "R3", "order", dst_word, last_pop);
               last_pop = dst_word;
               have_pop = 1;
               check(longint'($realtime - t) <= lat_limit(), "R7", "latency ns",
                     longint'($realtime - t), lat_limit());
            end
         end else begin
            check(dst_word == last_out, "R5", "word hold", dst_word, last_out);
         end
         last_out   = dst_word;
         last_valid = dst_valid;
      end
   end

   task automatic drive(input int n, input bit freeze);
      repeat (n) begin
         @(posedge src_clk);
         #2;
         src_prev = src_word;
         if (!freeze) src_word = src_word + DW'($urandom_range(0, 3));
      end
   endtask

   task automatic reset_state_check(input string tag);
      check(src_take == 1'b0, "R1", {tag, " src_take"}, src_take, 0);
      check(dst_valid == 1'b0, "R1", {tag, " dst_valid"}, dst_valid, 0);
      check(dst_word == '0, "R1", {tag, " dst_word"}, dst_word, 0);
   endtask

   task automatic release_resets();
      exp_q.delete();
      t_q.delete();
      takes = 0; valids = 0; gap = 100;
      last_out = '0; last_valid = 0; have_pop = 0;
      @(posedge src_clk);
      #2;
      src_prev = src_word;
      src_rst = 1'b0;
      dst_rst = 1'b0;
      mon_on = 1;
   endtask

   task automatic count_check(input string tag);
      check((takes - valids) >= 0 && (takes - valids) <= 1, "R4",
            {tag, " takes minus valids"}, takes - valids, 0);
      check(exp_q.size() <= 1, "R4", {tag, " in flight"}, exp_q.size(), 1);
      check(valids > 10, "R4", {tag, " progress"}, valids, 11);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      #1;
      src_rst = 1'b1;
      dst_rst = 1'b1;
      #40;
      reset_state_check("power-on");
      release_resets();

      // phase A: destination slower than source, random steps (R3, R7)
      drive(1200, 1'b0);
      // directed: frozen producer word, repeated equal values
      drive(150, 1'b0);
      drive(200, 1'b1);
      drive(100, 1'b0);
      count_check("slow dst");

      // directed: both resets mid-transfer at an unaligned time (R1)
      #3.3;
      mon_on = 0;
      src_rst = 1'b1;
      dst_rst = 1'b1;
      #30;
      reset_state_check("mid-run");
      dst_half = 3.25;
      #20;
      release_resets();

      // phase B: destination faster than source (R7)
      drive(1200, 1'b0);
      drive(50, 1'b1);
      drive(200, 1'b0);
      count_check("fast dst");

      summary();
      $finish;
   end

   initial begin
      #2ms;
      if (!done) begin
         check(1'b0, "R4", "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

endmodule